// File: doc/BRIEF.md
# Pulsed Byte Programming Controller

This block sits on the host side of a parallel flash device and writes one byte into it with a closed loop. Each pass through the loop does four things. It writes a program-setup command and then the data byte at the target address. It waits a fixed pulse time, counted in clock cycles. It writes the verify command, waits a short settling time and reads the byte back. The loop ends when the read-back equals the intended byte, or when the permitted number of pulses has been used up.

The block drives the device's high programming supply for the whole exchange. When the result is known, it returns the device to read mode, drops the supply and raises `done`, with `pass` giving the outcome. The caller walks through a multi-byte image one byte at a time: it issues a start with an address and a byte, then waits for `done`.

Top module: `byte_pulse_prog`

## Requirements
- R1: While reset is held and after it is released, `done`, `pass`, `vpp_en`, `dev_we` and `dev_re` are all 0 until a start is accepted.
- R2: Each loop iteration issues exactly three one-cycle device writes, in this order: the setup command (40h), then the data byte at the start address, then the verify command C0h. `dev_we` and `dev_re` are never high in the same cycle.
- R3: The verify-command write happens exactly `PULSE_CYC`+1 cycles after the data write.
- R4: The read strobe `dev_re` is high for one cycle, exactly `SETTLE_CYC`+1 cycles after the verify command, at the start address.
- R5: If the read-back equals the byte on iteration n (n ≤ `MAX_PULSES`), the block finishes with `pass`=1 and `pulses_used`=n, and issues no further data write.
- R6: If every read-back mismatches, the block stops after exactly `MAX_PULSES` data writes and finishes with `pass`=0 and `pulses_used`=`MAX_PULSES`.
- R7: `vpp_en` rises in the cycle after a start is accepted and stays high through the last device write. It falls in the same cycle that `done` rises, and every device strobe occurs while it is high.
- R8: After the result is decided, one write of the read-mode command 00h follows. `done` is high from the next cycle on.
- R9: An accepted start clears `done` and `pass` in the next cycle and restarts the pulse count from zero. Outside a start, `done` and `pass` hold their values.
- R10: A start raised while a sequence is running is ignored: the address, the data and the pulse count of the running sequence are unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| start | input | 1 | Start request, taken when idle |
| start_addr | input | AW | Target byte address |
| start_data | input | 8 | Byte to program |
| done | output | 1 | Result valid, held until next start |
| pass | output | 1 | Byte verified (valid with done) |
| pulses_used | output | CW | Pulses issued for the current/last byte |
| vpp_en | output | 1 | High programming supply enable |
| dev_we | output | 1 | One-cycle device write strobe |
| dev_re | output | 1 | One-cycle device read strobe |
| dev_addr | output | AW | Device address |
| dev_wdata | output | 8 | Device write data / command |
| dev_rdata | input | 8 | Device read data, sampled while dev_re is high |

## Verification
Most faults in the state register or the timers appear at the device pins within one loop iteration. A skipped or repeated state changes the order of the three writes. A timer off by one moves the verify write or the read strobe by a cycle against the data write. A faulty pulse counter shows up only at the end of a byte, as a wrong `pulses_used`, a wrong `pass`, or an extra or missing data write. For that reason the bench sweeps the number of pulses the device needs from one to past the limit.

// File: rtl/bpp_pkg.sv
package bpp_pkg;
    typedef enum logic [2:0] {
        ST_IDLE,
        ST_SETUP,
        ST_LOAD,
        ST_PULSE,
        ST_VCMD,
        ST_SETTLE,
        ST_READ,
        ST_FINISH
    } bpp_state_e;
endpackage

// File: rtl/bpp_timer.sv
module bpp_timer #(
    parameter int W = 8
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         load,
    input  logic [W-1:0] load_val,
    output logic         expired
);
    logic [W-1:0] cnt_d, cnt_q;

    always_comb begin
        cnt_d = cnt_q;
        if (load)
            cnt_d = load_val;
        else if (cnt_q != '0)
            cnt_d = cnt_q - 1'b1;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) cnt_q <= '0;
        else        cnt_q <= cnt_d;
    end

    assign expired = (cnt_q == '0);
endmodule

// File: rtl/bpp_pulse_ctr.sv
module bpp_pulse_ctr #(
    parameter int MAXP = 25,
    parameter int W    = 5
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         clear,
    input  logic         inc,
    output logic [W-1:0] count,
    output logic         at_limit
);
    localparam logic [W-1:0] LIMIT = W'(MAXP);

    logic [W-1:0] cnt_d, cnt_q;

    always_comb begin
        cnt_d = cnt_q;
        if (clear)
            cnt_d = '0;
        else if (inc && cnt_q != LIMIT)
            cnt_d = cnt_q + 1'b1;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) cnt_q <= '0;
        else        cnt_q <= cnt_d;
    end

    assign count    = cnt_q;
    assign at_limit = (cnt_q == LIMIT);
endmodule

// File: rtl/byte_pulse_prog.sv
module byte_pulse_prog #(
    parameter int          AW         = 17,
    parameter int          MAX_PULSES = 25,
    parameter int          PULSE_CYC  = 2500,
    parameter int          SETTLE_CYC = 4,
    parameter logic [7:0]  CMD_SETUP  = 8'h40,
    parameter logic [7:0]  CMD_VERIFY = 8'hC0,
    parameter logic [7:0]  CMD_READ   = 8'h00,
    localparam int         CW         = $clog2(MAX_PULSES + 1)
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          start,
    input  logic [AW-1:0] start_addr,
    input  logic [7:0]    start_data,
    output logic          done,
    output logic          pass,
    output logic [CW-1:0] pulses_used,
    output logic          vpp_en,
    output logic          dev_we,
    output logic          dev_re,
    output logic [AW-1:0] dev_addr,
    output logic [7:0]    dev_wdata,
    input  logic [7:0]    dev_rdata
);
    import bpp_pkg::*;

    localparam int TMAX = (PULSE_CYC > SETTLE_CYC) ? PULSE_CYC : SETTLE_CYC;
    localparam int TW   = $clog2(TMAX + 1);
    localparam logic [TW-1:0] PULSE_LD  = TW'(PULSE_CYC - 1);
    localparam logic [TW-1:0] SETTLE_LD = TW'(SETTLE_CYC - 1);

    typedef struct packed {
        bpp_state_e    state;
        logic [AW-1:0] addr;
        logic [7:0]    data;
        logic          done;
        logic          pass;
    } ctl_t;

    ctl_t s_d, s_q;

    logic          tmr_load;
    logic [TW-1:0] tmr_val;
    logic          tmr_exp;
    logic          ctr_clr;
    logic          ctr_inc;
    logic          ctr_lim;
    logic [CW-1:0] ctr_cnt;

    bpp_timer #(.W(TW)) u_timer (
        .clk      (clk),
        .rst_n    (rst_n),
        .load     (tmr_load),
        .load_val (tmr_val),
        .expired  (tmr_exp)
    );

    bpp_pulse_ctr #(.MAXP(MAX_PULSES), .W(CW)) u_ctr (
        .clk      (clk),
        .rst_n    (rst_n),
        .clear    (ctr_clr),
        .inc      (ctr_inc),
        .count    (ctr_cnt),
        .at_limit (ctr_lim)
    );

    always_comb begin
        s_d       = s_q;
        tmr_load  = 1'b0;
        tmr_val   = PULSE_LD;
        ctr_clr   = 1'b0;
        ctr_inc   = 1'b0;
        dev_we    = 1'b0;
        dev_re    = 1'b0;
        dev_wdata = CMD_READ;
        unique case (s_q.state)
            ST_IDLE: begin
                if (start) begin
                    s_d.addr  = start_addr;
                    s_d.data  = start_data;
                    s_d.done  = 1'b0;
                    s_d.pass  = 1'b0;
                    ctr_clr   = 1'b1;
                    s_d.state = ST_SETUP;
                end
            end
            ST_SETUP: begin
                dev_we    = 1'b1;
                dev_wdata = CMD_SETUP;
                s_d.state = ST_LOAD;
            end
            ST_LOAD: begin
                dev_we    = 1'b1;
                dev_wdata = s_q.data;
                ctr_inc   = 1'b1;
                tmr_load  = 1'b1;
                tmr_val   = PULSE_LD;
                s_d.state = ST_PULSE;
            end
            ST_PULSE: begin
                if (tmr_exp) s_d.state = ST_VCMD;
            end
            ST_VCMD: begin
                dev_we    = 1'b1;
                dev_wdata = CMD_VERIFY;
                tmr_load  = 1'b1;
                tmr_val   = SETTLE_LD;
                s_d.state = ST_SETTLE;
            end
            ST_SETTLE: begin
                if (tmr_exp) s_d.state = ST_READ;
            end
            ST_READ: begin
                dev_re = 1'b1;
                if (dev_rdata == s_q.data) begin
                    s_d.pass  = 1'b1;
                    s_d.state = ST_FINISH;
                end else if (ctr_lim) begin
                    s_d.state = ST_FINISH;
                end else begin
                    s_d.state = ST_SETUP;
                end
            end
            ST_FINISH: begin
                dev_we    = 1'b1;
                dev_wdata = CMD_READ;
                s_d.done  = 1'b1;
                s_d.state = ST_IDLE;
            end
            default: s_d.state = ST_IDLE;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            s_q.state <= ST_IDLE;
            s_q.addr  <= '0;
            s_q.data  <= '0;
            s_q.done  <= 1'b0;
            s_q.pass  <= 1'b0;
        end else begin
            s_q <= s_d;
        end
    end

    assign vpp_en      = (s_q.state != ST_IDLE);
    assign dev_addr    = s_q.addr;
    assign done        = s_q.done;
    assign pass        = s_q.pass;
    assign pulses_used = ctr_cnt;
endmodule

// File: rtl/bpp_checker.sv
module bpp_checker #(
    parameter int MAXP = 25,
    parameter int CW   = 5
) (
    input logic          clk,
    input logic          rst_n,
    input logic          start,
    input logic          done,
    input logic          pass,
    input logic [CW-1:0] pulses_used,
    input logic          vpp_en,
    input logic          dev_we,
    input logic          dev_re
);
    assert_strobe_excl_R2: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0({dev_we, dev_re}));

    assert_read_supply_R7: assert property (@(posedge clk) disable iff (!rst_n)
        (dev_re || dev_we) |-> vpp_en);

    assert_supply_drop_R7: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(vpp_en) |-> done);

    assert_done_idle_R8: assert property (@(posedge clk) disable iff (!rst_n)
        done |-> !vpp_en);

    assert_pulse_limit_R6: assert property (@(posedge clk) disable iff (!rst_n)
        32'(pulses_used) <= MAXP);

    assert_result_hold_R9: assert property (@(posedge clk) disable iff (!rst_n)
        (done && !start) |=> (done && $stable(pass)));
endmodule

bind byte_pulse_prog bpp_checker #(.MAXP(MAX_PULSES), .CW(CW)) u_chk (
    .clk         (clk),
    .rst_n       (rst_n),
    .start       (start),
    .done        (done),
    .pass        (pass),
    .pulses_used (pulses_used),
    .vpp_en      (vpp_en),
    .dev_we      (dev_we),
    .dev_re      (dev_re)
);

// File: tb/byte_pulse_prog_tb.sv
module byte_pulse_prog_tb;
    localparam int AW     = 8;
    localparam int MAXP   = 4;
    localparam int PULSE  = 3;
    localparam int SETTLE = 2;
    localparam int CW     = $clog2(MAXP + 1);

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic          start = 1'b0;
    logic [AW-1:0] start_addr = '0;
    logic [7:0]    start_data = '0;
    logic          done, pass, vpp_en, dev_we, dev_re;
    logic [CW-1:0] pulses_used;
    logic [AW-1:0] dev_addr;
    logic [7:0]    dev_wdata;
    logic [7:0]    dev_rdata;

    int total = 0;
    int bad = 0;
    bit finished = 0;

    // device model state
    int            k_need = 1;
    int            dev_pulses = 0;
    logic [AW-1:0] exp_addr = '0;
    logic [7:0]    exp_data = '0;
    int            phase = 0;
    int            cyc = 0;
    int            t_data = 0;
    int            t_ver = 0;
    int            t_fin = -10;

    always #2 clk = ~clk;

    byte_pulse_prog #(
        .AW(AW), .MAX_PULSES(MAXP), .PULSE_CYC(PULSE), .SETTLE_CYC(SETTLE)
    ) u_dut (
        .clk(clk), .rst_n(rst_n), .start(start), .start_addr(start_addr),
        .start_data(start_data), .done(done), .pass(pass),
        .pulses_used(pulses_used), .vpp_en(vpp_en), .dev_we(dev_we),
        .dev_re(dev_re), .dev_addr(dev_addr), .dev_wdata(dev_wdata),
        .dev_rdata(dev_rdata)
    );

    assign dev_rdata = (dev_pulses >= k_need) ? exp_data : (exp_data ^ 8'h81);

    task automatic check(input bit ok, input string req, input int act, input int exp);
        total++;
        if (!ok) begin
            bad++;
            $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
        end
    endtask

    // bus monitor
    always @(negedge clk) begin
        if (rst_n && !finished) begin
            cyc++;
            if (cyc == t_fin + 1) begin
                check(done == 1'b1, "R8 done after read-mode write", int'(done), 1);
                check(vpp_en == 1'b0, "R7 supply off with done", int'(vpp_en), 0);
            end
            if ((dev_we || dev_re) && !vpp_en)
                check(1'b0, "R7 strobe without supply", 0, 1);
            if (dev_we && dev_re)
                check(1'b0, "R2 strobes overlap", 1, 0);
            if (dev_we) begin
                case (phase)
                    0: begin
                        if (dev_wdata == 8'h40) phase = 1;
                        else if (dev_wdata == 8'h00) t_fin = cyc;
                        else check(1'b0, "R2 expected setup or read cmd", int'(dev_wdata), 'h40);
                    end
                    1: begin
                        check(dev_wdata == exp_data, "R2 data byte", int'(dev_wdata), int'(exp_data));
                        check(dev_addr == exp_addr, "R10 data address", int'(dev_addr), int'(exp_addr));
                        dev_pulses++;
                        t_data = cyc;
                        phase = 2;
                    end
                    2: begin
                        check(dev_wdata == 8'hC0, "R2 verify cmd", int'(dev_wdata), 'hC0);
                        check(cyc == t_data + PULSE + 1, "R3 pulse length", cyc - t_data, PULSE + 1);
                        t_ver = cyc;
                        phase = 3;
                    end
                    default: check(1'b0, "R4 write during settle", int'(dev_wdata), 0);
                endcase
            end
            if (dev_re) begin
                check(phase == 3, "R4 read out of order", phase, 3);
                check(cyc == t_ver + SETTLE + 1, "R4 settle length", cyc - t_ver, SETTLE + 1);
                check(dev_addr == exp_addr, "R4 read address", int'(dev_addr), int'(exp_addr));
                phase = 0;
            end
        end
    end

    task automatic run(input int k, input logic [AW-1:0] a, input logic [7:0] d, input bit poke);
        int exp_p;
        bit exp_pass;
        logic saved;
        exp_pass = (k <= MAXP);
        exp_p    = exp_pass ? k : MAXP;
        @(negedge clk);
        k_need = k; dev_pulses = 0; exp_addr = a; exp_data = d; phase = 0;
        start = 1'b1; start_addr = a; start_data = d;
        @(negedge clk);
        start = 1'b0;
        check(done == 1'b0 && pass == 1'b0, "R9 start clears result", int'(done), 0);
        check(vpp_en == 1'b1, "R7 supply on after start", int'(vpp_en), 1);
        if (poke) begin
            repeat (5) @(negedge clk);
            start = 1'b1; start_addr = ~a; start_data = ~d;
            @(negedge clk);
            start = 1'b0;
        end
        for (int i = 0; i < 2000 && !done; i++) @(negedge clk);
        check(done == 1'b1, "R5 done reached", int'(done), 1);
        check(pass == exp_pass, exp_pass ? "R5 pass" : "R6 fail", int'(pass), int'(exp_pass));
        check(int'(pulses_used) == exp_p, exp_pass ? "R5 pulse count" : "R6 pulse count",
              int'(pulses_used), exp_p);
        check(dev_pulses == exp_p, poke ? "R10 data writes" : "R6 data writes", dev_pulses, exp_p);
        saved = pass;
        repeat (3) @(negedge clk);
        check(done == 1'b1 && pass == saved, "R9 result held", int'(pass), int'(saved));
    endtask

    initial begin
        repeat (3) @(negedge clk);
        check(done == 0 && pass == 0 && vpp_en == 0 && dev_we == 0 && dev_re == 0,
              "R1 reset outputs", int'({done, pass, vpp_en, dev_we, dev_re}), 0);
        rst_n = 1'b1;
        repeat (2) @(negedge clk);
        check(done == 0 && vpp_en == 0 && dev_we == 0 && dev_re == 0,
              "R1 idle after reset", int'({done, vpp_en, dev_we, dev_re}), 0);
        for (int k = 1; k <= MAXP + 2; k++) begin
            run(k, AW'(8'h10 + k), 8'h3C, 1'b0);
            run(k, AW'(8'hE0 - k), 8'hA5 ^ 8'(k), 1'b0);
            run(k, AW'(8'h7F), 8'(k * 37), 1'b0);
        end
        run(2, 8'h55, 8'h96, 1'b1);
        run(MAXP + 1, 8'h22, 8'h01, 1'b1);
        run(1, 8'h00, 8'hFE, 1'b0);
        if (!finished) begin
            finished = 1;
            $display("test done: total=%0d bad=%0d", total, bad);
            $finish;
        end
    end

    initial begin
        repeat (200000) @(posedge clk);
        if (!finished) begin
            finished = 1;
            check(1'b0, "R5 watchdog expired", 0, 1);
            $display("test done: total=%0d bad=%0d", total, bad);
            $finish;
        end
    end
endmodule